// File: doc/BRIEF.md
# Debug communications channel mailbox

This block is a pair of one-word mailboxes that move 32-bit values between software on a running processor and an external debugger. Traffic from the debugger to the processor goes through the receive mailbox. Traffic from the processor to the debugger goes through the transmit mailbox. Each mailbox holds one word and has one full flag.

The processor reaches the block through a coprocessor-style port. That port has one shared data register and one status register. A write to the data register fills the transmit mailbox. A read of the data register drains the receive mailbox.

The debugger reaches the block through a memory-mapped port. That port has a separate receive data register, a separate transmit data register and the same status register. The debugger side always runs nonblocking: a write to a full mailbox or a read from an empty mailbox is dropped and leaves no trace.

Both ports take one access per cycle and never stall. No handshake applies back-pressure. Instead, software on either side polls the full flags in the status word before it reads or writes a data register. Read data is combinational in the cycle of the read. The flag update of an access lands at the next clock edge, so the very next access already sees it and no flush or barrier step is needed between two accesses.

Top module: `dcc_mailbox`

## Requirements
- R1: A synchronous active-high `rst` clears both full flags and both stored words to zero.
- R2: A status read on either port returns the receive-full flag in bit 30 and the transmit-full flag in bit 29. All other bits read as zero.
- R3: A processor write to the data register (`cpu_sel`=0) while the transmit mailbox is empty stores the whole word and sets the transmit-full flag. A later debugger read of the transmit register (`dbg_sel`=2) returns that word and clears the flag.
- R4: A processor read of the data register while the receive mailbox is full returns the stored word and clears the receive-full flag.
- R5: A debugger write to the receive register (`dbg_sel`=1) while the receive mailbox is empty stores the word and sets the receive-full flag.
- R6: A debugger write to the receive register while the receive mailbox is full is ignored. The stored word and the flag are unchanged.
- R7: A debugger read of the transmit register while the transmit mailbox is empty returns zero and leaves the flag unchanged.
- R8: Two processor accesses are ignored and change no state: a write to the data register while the transmit mailbox is full, and a read of the data register while the receive mailbox is empty. That read returns zero.
- R9: A flag change made by an access is visible to an access in the very next cycle.
- R10: When a drain and a fill of the same mailbox arrive in the same cycle on a full mailbox, both are accepted. The read returns the old word, the new word is stored, and the flag stays set.
- R11: The following have no effect on any state: writes to the status register (processor `cpu_sel`=1, debugger `dbg_sel`=0), debugger writes to `dbg_sel`=2 or 3, and debugger reads of `dbg_sel`=1 or 3. Any read data output not serving a read in that cycle drives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_sel | input | 1 | Processor register: 0 data, 1 status |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Processor read word, valid in the access cycle |
| dbg_req | input | 1 | Debugger access strobe |
| dbg_we | input | 1 | Debugger write (1) or read (0) |
| dbg_sel | input | 2 | Debugger register: 0 status, 1 receive data, 2 transmit data, 3 unused |
| dbg_wdata | input | 32 | Debugger write word |
| dbg_rdata | output | 32 | Debugger read word, valid in the access cycle |

## Verification
The bound checker watches the following on every cycle:
- the status bit layout on both ports;
- the setting of each flag together with the word it captures;
- the drop of a debugger write to a full receive mailbox;
- the zero returned by reads of empty mailboxes;
- the fill-over-drain outcome of same-cycle accesses.

Some behaviours only the bench scenarios can show. These are the end-to-end ordering of words through each mailbox, the survival of the first word across a dropped second write, the reset state, and the fact that accesses to unused selectors leave both mailboxes untouched.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int DCC_WORD_W   = 32;
  localparam int RX_FULL_BIT  = 30;
  localparam int TX_FULL_BIT  = 29;
  localparam int NUM_DIR      = 2;
  localparam int DIR_RX       = 0;  // debugger to processor
  localparam int DIR_TX       = 1;  // processor to debugger

  localparam logic       CPU_SEL_DATA = 1'b0;
  localparam logic       CPU_SEL_STAT = 1'b1;
  localparam logic [1:0] DBG_SEL_STAT = 2'd0;
  localparam logic [1:0] DBG_SEL_RX   = 2'd1;
  localparam logic [1:0] DBG_SEL_TX   = 2'd2;
endpackage

// File: rtl/dcc_slot.sv
// One single-word mailbox with a full flag. A drain accepted in a cycle
// frees the slot for a fill arriving in the same cycle.
module dcc_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  input  logic          drain,
  output logic          full,
  output logic [DW-1:0] word
);
  logic drain_ok;
  logic fill_ok;

  assign drain_ok = drain & full;
  assign fill_ok  = fill & (~full | drain_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      if (fill_ok) begin
        full <= 1'b1;
        word <= fill_data;
      end else if (drain_ok) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dcc_cpu_port.sv
// Processor-side decode: shared data register and status register.
module dcc_cpu_port
  import dcc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          req,
  input  logic          we,
  input  logic          sel,
  input  logic          rx_full,
  input  logic [DW-1:0] rx_word,
  input  logic [DW-1:0] status,
  output logic          tx_fill,
  output logic          rx_drain,
  output logic [DW-1:0] rdata
);
  logic hit_data;

  assign hit_data = req & (sel == CPU_SEL_DATA);
  assign tx_fill  = hit_data & we;
  assign rx_drain = hit_data & ~we;

  always_comb begin
    rdata = '0;
    if (req && !we) begin
      if (sel == CPU_SEL_STAT) rdata = status;
      else if (rx_full)        rdata = rx_word;
    end
  end
endmodule

// File: rtl/dcc_dbg_port.sv
// Debugger-side decode: separate receive and transmit registers, status.
module dcc_dbg_port
  import dcc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          req,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic          tx_full,
  input  logic [DW-1:0] tx_word,
  input  logic [DW-1:0] status,
  output logic          rx_fill,
  output logic          tx_drain,
  output logic [DW-1:0] rdata
);
  assign rx_fill  = req & we  & (sel == DBG_SEL_RX);
  assign tx_drain = req & ~we & (sel == DBG_SEL_TX);

  always_comb begin
    rdata = '0;
    if (req && !we) begin
      case (sel)
        DBG_SEL_STAT: rdata = status;
        DBG_SEL_TX:   rdata = tx_full ? tx_word : '0;
        default:      rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
  import dcc_pkg::*;
#(
  parameter int DW = DCC_WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dbg_req,
  input  logic          dbg_we,
  input  logic [1:0]    dbg_sel,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata
);
  logic [NUM_DIR-1:0] fill;
  logic [NUM_DIR-1:0] drain;
  logic [NUM_DIR-1:0] full;
  logic [DW-1:0]      fdata [NUM_DIR];
  logic [DW-1:0]      word  [NUM_DIR];

  logic          rx_full, tx_full;
  logic [DW-1:0] rx_word, tx_word;
  logic [DW-1:0] status;

  assign rx_full = full[DIR_RX];
  assign tx_full = full[DIR_TX];
  assign rx_word = word[DIR_RX];
  assign tx_word = word[DIR_TX];

  always_comb begin
    status = '0;
    status[RX_FULL_BIT] = rx_full;
    status[TX_FULL_BIT] = tx_full;
  end

  assign fdata[DIR_RX] = dbg_wdata;
  assign fdata[DIR_TX] = cpu_wdata;

  dcc_cpu_port #(.DW(DW)) u_cpu (
    .req      (cpu_req),
    .we       (cpu_we),
    .sel      (cpu_sel),
    .rx_full  (rx_full),
    .rx_word  (rx_word),
    .status   (status),
    .tx_fill  (fill[DIR_TX]),
    .rx_drain (drain[DIR_RX]),
    .rdata    (cpu_rdata)
  );

  dcc_dbg_port #(.DW(DW)) u_dbg (
    .req      (dbg_req),
    .we       (dbg_we),
    .sel      (dbg_sel),
    .tx_full  (tx_full),
    .tx_word  (tx_word),
    .status   (status),
    .rx_fill  (fill[DIR_RX]),
    .tx_drain (drain[DIR_TX]),
    .rdata    (dbg_rdata)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    dcc_slot #(.DW(DW)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .fill      (fill[d]),
      .fill_data (fdata[d]),
      .drain     (drain[d]),
      .full      (full[d]),
      .word      (word[d])
    );
  end
endmodule

// File: rtl/dcc_mailbox_chk.sv
module dcc_mailbox_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_sel,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          dbg_req,
  input logic          dbg_we,
  input logic [1:0]    dbg_sel,
  input logic [DW-1:0] dbg_wdata,
  input logic [DW-1:0] dbg_rdata,
  input logic          rx_full,
  input logic          tx_full,
  input logic [DW-1:0] rx_word,
  input logic [DW-1:0] tx_word
);
  logic cpu_rd_data, cpu_wr_data, cpu_rd_stat, dbg_wr_rx, dbg_rd_tx, dbg_rd_stat;
  assign cpu_rd_data = cpu_req && !cpu_we && cpu_sel == 1'b0;
  assign cpu_wr_data = cpu_req &&  cpu_we && cpu_sel == 1'b0;
  assign cpu_rd_stat = cpu_req && !cpu_we && cpu_sel == 1'b1;
  assign dbg_wr_rx   = dbg_req &&  dbg_we && dbg_sel == 2'd1;
  assign dbg_rd_tx   = dbg_req && !dbg_we && dbg_sel == 2'd2;
  assign dbg_rd_stat = dbg_req && !dbg_we && dbg_sel == 2'd0;

  // R2
  p_cpu_status_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_stat |-> cpu_rdata[30] == rx_full && cpu_rdata[29] == tx_full
                    && cpu_rdata[31] == 1'b0 && cpu_rdata[28:0] == '0);
  p_dbg_status_r2: assert property (@(posedge clk) disable iff (rst)
    dbg_rd_stat |-> dbg_rdata[30] == rx_full && dbg_rdata[29] == tx_full
                    && dbg_rdata[31] == 1'b0 && dbg_rdata[28:0] == '0);
  // R3
  p_tx_fill_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_data && !tx_full |=> tx_full && tx_word == $past(cpu_wdata));
  // R4
  p_rx_drain_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_data && rx_full && !dbg_wr_rx |=> !rx_full);
  // R5
  p_rx_fill_r5: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_rx && !rx_full |=> rx_full && rx_word == $past(dbg_wdata));
  // R6
  p_rx_drop_r6: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_rx && rx_full && !cpu_rd_data |=> rx_full && $stable(rx_word));
  // R7
  p_tx_empty_r7: assert property (@(posedge clk) disable iff (rst)
    dbg_rd_tx && !tx_full |-> dbg_rdata == '0);
  p_tx_empty_keep_r7: assert property (@(posedge clk) disable iff (rst)
    dbg_rd_tx && !tx_full && !cpu_wr_data |=> !tx_full);
  // R8
  p_rx_empty_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_data && !rx_full |-> cpu_rdata == '0);
  p_tx_drop_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_data && tx_full && !dbg_rd_tx |=> tx_full && $stable(tx_word));
  // R10
  p_rx_both_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_data && rx_full && dbg_wr_rx |=> rx_full && rx_word == $past(dbg_wdata));
  p_tx_both_r10: assert property (@(posedge clk) disable iff (rst)
    dbg_rd_tx && tx_full && cpu_wr_data |=> tx_full && tx_word == $past(cpu_wdata));
endmodule

bind dcc_mailbox dcc_mailbox_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_sel(dbg_sel),
  .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
  .rx_full(rx_full), .tx_full(tx_full), .rx_word(rx_word), .tx_word(tx_word)
);

// File: tb/sim_dcc_mailbox.sv
`timescale 1ns/1ps
module sim_dcc_mailbox;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req, cpu_we, cpu_sel;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        dbg_req, dbg_we;
  logic [1:0]  dbg_sel;
  logic [31:0] dbg_wdata, dbg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the mailbox state
  bit          m_rx_full, m_tx_full;
  logic [31:0] m_rx_word, m_tx_word;

  always #10 clk = ~clk;  // 50 MHz

  dcc_mailbox u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_sel(dbg_sel),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  function automatic logic [31:0] stat_word(bit rx, bit tx);
    logic [31:0] s = '0;
    s[30] = rx;
    s[29] = tx;
    return s;
  endfunction

  function automatic logic [31:0] exp_cpu(bit rq, bit we, bit sel);
    if (!rq || we) return '0;
    if (sel) return stat_word(m_rx_full, m_tx_full);
    return m_rx_full ? m_rx_word : '0;
  endfunction

  function automatic logic [31:0] exp_dbg(bit rq, bit we, logic [1:0] sel);
    if (!rq || we) return '0;
    if (sel == 2'd0) return stat_word(m_rx_full, m_tx_full);
    if (sel == 2'd2) return m_tx_full ? m_tx_word : '0;
    return '0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic string cpu_tag(bit rq, bit we, bit sel);
    if (!rq || we) return "R11 cpu idle read data";
    if (sel) return "R2 cpu status";
    return m_rx_full ? "R4 cpu data read" : "R8 cpu empty read";
  endfunction

  function automatic string dbg_tag(bit rq, bit we, logic [1:0] sel);
    if (!rq || we) return "R11 dbg idle read data";
    if (sel == 2'd0) return "R2 dbg status";
    if (sel == 2'd2) return m_tx_full ? "R3 dbg tx read" : "R7 dbg empty read";
    return "R11 dbg unused read";
  endfunction

  // One access cycle on both ports: drive, check combinational read data,
  // then advance the model as the clock edge will.
  task automatic step(bit crq, bit cwe, bit csel, logic [31:0] cwd,
                      bit drq, bit dwe, logic [1:0] dsel, logic [31:0] dwd);
    bit rx_drain, rx_fill, tx_drain, tx_fill;
    @(negedge clk);
    cpu_req = crq; cpu_we = cwe; cpu_sel = csel; cpu_wdata = cwd;
    dbg_req = drq; dbg_we = dwe; dbg_sel = dsel; dbg_wdata = dwd;
    #1;
    check(cpu_tag(crq, cwe, csel), cpu_rdata, exp_cpu(crq, cwe, csel));
    check(dbg_tag(drq, dwe, dsel), dbg_rdata, exp_dbg(drq, dwe, dsel));
    rx_drain = crq && !cwe && !csel && m_rx_full;
    rx_fill  = drq && dwe && dsel == 2'd1 && (!m_rx_full || rx_drain);
    tx_drain = drq && !dwe && dsel == 2'd2 && m_tx_full;
    tx_fill  = crq && cwe && !csel && (!m_tx_full || tx_drain);
    if (rx_fill) begin m_rx_full = 1'b1; m_rx_word = dwd; end
    else if (rx_drain) m_rx_full = 1'b0;
    if (tx_fill) begin m_tx_full = 1'b1; m_tx_word = cwd; end
    else if (tx_drain) m_tx_full = 1'b0;
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 0, 0, 2'd0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cpu_req = 0; cpu_we = 0; cpu_sel = 0; cpu_wdata = '0;
    dbg_req = 0; dbg_we = 0; dbg_sel = 2'd0; dbg_wdata = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_rx_full = 0; m_tx_full = 0; m_rx_word = '0; m_tx_word = '0;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0d0c);
    do_reset();

    // R1: reset state seen on both ports
    step(1, 0, 1, '0, 1, 0, 2'd0, '0);          // status both sides: 0
    check("R1 cpu status after reset", cpu_rdata, 32'h0);
    step(1, 0, 0, '0, 1, 0, 2'd2, '0);          // data reads empty: 0
    check("R1 dbg tx after reset", dbg_rdata, 32'h0);

    // R5, R9: debugger fill then immediate status
    step(0, 0, 0, '0, 1, 1, 2'd1, 32'hA5A5_0001);
    step(1, 0, 1, '0, 0, 0, 2'd0, '0);
    check("R9 rx flag next cycle", cpu_rdata, 32'h4000_0000);
    // R6: second write dropped, first word survives
    step(0, 0, 0, '0, 1, 1, 2'd1, 32'hDEAD_BEEF);
    step(1, 0, 0, '0, 0, 0, 2'd0, '0);
    check("R6 first word kept", cpu_rdata, 32'hA5A5_0001);
    step(1, 0, 1, '0, 0, 0, 2'd0, '0);
    check("R4 rx flag cleared", cpu_rdata, 32'h0);

    // R3, R8: processor fill, dropped second fill, debugger drain
    step(1, 1, 0, 32'h1234_5678, 0, 0, 2'd0, '0);
    step(1, 1, 0, 32'h8765_4321, 1, 0, 2'd0, '0);
    check("R3 tx flag in status", dbg_rdata, 32'h2000_0000);
    step(0, 0, 0, '0, 1, 0, 2'd2, '0);
    check("R8 tx word kept", dbg_rdata, 32'h1234_5678);
    step(0, 0, 0, '0, 1, 0, 2'd2, '0);
    check("R7 empty tx read", dbg_rdata, 32'h0);

    // R10: same-cycle drain and fill on both full mailboxes
    step(1, 1, 0, 32'h0000_00AA, 1, 1, 2'd1, 32'h0000_00BB);
    step(1, 0, 0, '0, 1, 1, 2'd1, 32'h0000_00CC);
    check("R10 rx old word out", cpu_rdata, 32'h0000_00BB);
    step(1, 1, 0, 32'h0000_00DD, 1, 0, 2'd2, '0);
    check("R10 tx old word out", dbg_rdata, 32'h0000_00AA);
    step(1, 0, 1, '0, 0, 0, 2'd0, '0);
    check("R10 both flags set", cpu_rdata, 32'h6000_0000);
    step(1, 0, 0, '0, 1, 0, 2'd2, '0);
    check("R10 rx new word", cpu_rdata, 32'h0000_00CC);
    check("R10 tx new word", dbg_rdata, 32'h0000_00DD);

    // R11: writes to status and unused selectors change nothing
    step(1, 1, 1, 32'hFFFF_FFFF, 1, 1, 2'd0, 32'hFFFF_FFFF);
    step(0, 0, 0, '0, 1, 1, 2'd2, 32'hFFFF_FFFF);
    step(0, 0, 0, '0, 1, 1, 2'd3, 32'hFFFF_FFFF);
    step(1, 0, 1, '0, 1, 0, 2'd1, '0);
    check("R11 flags untouched", cpu_rdata, 32'h0);

    // Constrained random mix, checked against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step(r[0], r[1], r[2], $urandom, r[3], r[4], r[6:5], $urandom);
    end

    // R1: reset from a busy state
    step(1, 1, 0, 32'h7777_7777, 1, 1, 2'd1, 32'h3333_3333);
    do_reset();
    step(1, 0, 1, '0, 1, 0, 2'd2, '0);
    check("R1 status after second reset", cpu_rdata, 32'h0);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule